// File: doc/BRIEF.md
# Self-Timed Byte Store Controller

This block fronts a 128-byte non-volatile data store, modelled here as a register array. A CPU reaches it through three memory-mapped registers on a simple register bus: a control/status register, a 7-bit location register and a byte data register. Software loads a location, then either requests a single-byte fetch or stores a single byte through a two-step arm-then-go sequence. A store runs for a fixed, parameterised number of clock cycles and is committed to the array when that interval ends.

Each accepted request stalls the CPU for a short fixed time. A fetch stalls it longer than a store. A ready interrupt tells software that the controller can take a new byte. The store engine has its own power-on reset. The ordinary system reset does not touch it, so a store that is running when the system reset is applied still finishes and commits.

Register offsets: 0 = control/status, 1 = location, 2 = data. Control bits on write: bit 0 interrupt enable, bit 1 arm, bit 2 store-go, bit 3 fetch-go. Control bits on read: bit 0 interrupt enable, bit 1 arm, bit 4 busy. All other control bits read as zero.

Top module: `nvbyte_ctrl`

## Requirements
- R1: The store holds 128 bytes, selected linearly 0..127 by the 7-bit location register (offset 1). A byte stored at any location, including 0 and 127, is returned by a later fetch of that location.
- R2: Bit 7 of the location register always reads as zero, and a 1 written to bit 7 is discarded.
- R3: Writing control bit 1 arms the controller. The arm bit reads 1 and then clears itself 4 cycles after the write. A store-go (bit 2) is accepted only if the arm bit was already set before that bus write. Without arming, the store-go is ignored: busy stays 0 and the stored byte is unchanged. An accepted store clears the arm bit.
- R4: An accepted store raises busy (control bit 4) for exactly WR_CYCLES cycles. The data byte is written to the array when busy falls.
- R5: A store in progress continues and commits even if the system reset `rst_n` is asserted during it. Only `por_n` can abort it.
- R6: `cpu_stall` is high for exactly 2 cycles after an accepted store-go and for exactly 4 cycles after an accepted fetch-go, starting in the cycle after the request.
- R7: While busy, a fetch-go is ignored (no stall, data unchanged), and writes to the location and data registers are discarded.
- R8: `ready_irq` is high exactly when interrupt enable (control bit 0) is set and the controller is not busy. The system reset clears the enable.
- R9: An accepted fetch-go loads the data register (offset 2) with the byte at the current location, in the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; the only reset of the store engine |
| rst_n | input | 1 | System reset, active low; clears arm, enable and stall |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| cpu_stall | output | 1 | Stall request to the CPU |
| ready_irq | output | 1 | Ready interrupt |

## Verification
Every cycle, the assertions check the following: stall lengths after each accepted request, that busy only rises when arming came first, that the arm bit expires on time, that the location and data registers hold while busy, that bit 7 of the location register is zero, and that the interrupt is low while busy. Some behaviour shows only in the bench scenarios: bytes really landing in the array, rejected stores leaving old contents in place, a store outliving a system-reset pulse, and the busy interval length measured at the ports.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
   localparam logic [1:0] OFS_CTRL = 2'd0;
   localparam logic [1:0] OFS_ADDR = 2'd1;
   localparam logic [1:0] OFS_DATA = 2'd2;
   localparam int B_IE   = 0;
   localparam int B_ARM  = 1;
   localparam int B_WGO  = 2;
   localparam int B_RGO  = 3;
   localparam int B_BUSY = 4;
endpackage

// File: rtl/nvb_regs.sv
module nvb_regs
   import nvb_pkg::*;
#(
   parameter int AW         = 7,
   parameter int DW         = 8,
   parameter int ARM_WINDOW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          busy,
   input  logic [DW-1:0] rd_byte,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] data_q,
   output logic          ie_q,
   output logic          arm,
   output logic          arm_set,
   output logic          wr_start,
   output logic          rd_start,
   output logic [DW-1:0] bus_rdata
);
   localparam int CW = $clog2(ARM_WINDOW + 1);

   logic          ctrl_wr;
   logic [CW-1:0] arm_cnt;
   logic [DW-1:0] ctrl_view;

   assign ctrl_wr  = rst_n && bus_we && (bus_addr == OFS_CTRL);
   assign arm_set  = ctrl_wr && bus_wdata[B_ARM];
   assign arm      = (arm_cnt != '0);
   assign wr_start = ctrl_wr && bus_wdata[B_WGO] && arm && !busy;
   assign rd_start = ctrl_wr && bus_wdata[B_RGO] && !bus_wdata[B_WGO] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_cnt <= '0;
         ie_q    <= 1'b0;
      end else begin
         if (ctrl_wr)
            ie_q <= bus_wdata[B_IE];
         if (wr_start)
            arm_cnt <= '0;
         else if (arm_set)
            arm_cnt <= CW'(ARM_WINDOW);
         else if (arm)
            arm_cnt <= arm_cnt - 1'b1;
      end
   end

   // location and data registers carry no reset value by design
   always_ff @(posedge clk) begin
      if (bus_we && (bus_addr == OFS_ADDR) && !busy)
         addr_q <= bus_wdata[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rd_start)
         data_q <= rd_byte;
      else if (bus_we && (bus_addr == OFS_DATA) && !busy)
         data_q <= bus_wdata;
   end

   always_comb begin
      ctrl_view         = '0;
      ctrl_view[B_IE]   = ie_q;
      ctrl_view[B_ARM]  = arm;
      ctrl_view[B_BUSY] = busy;
   end

   always_comb begin
      case (bus_addr)
         OFS_CTRL: bus_rdata = ctrl_view;
         OFS_ADDR: bus_rdata = {{(DW-AW){1'b0}}, addr_q};
         OFS_DATA: bus_rdata = data_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/nvb_wr_engine.sv
module nvb_wr_engine #(
   parameter int WR_CYCLES = 64
) (
   input  logic clk,
   input  logic por_n,
   input  logic start,
   output logic busy,
   output logic commit
);
   localparam int TW = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;

   logic [TW-1:0] tmr;

   assign commit = busy && (tmr == '0);

   // only power-on reset: a running store survives the system reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy <= 1'b0;
         tmr  <= '0;
      end else if (busy) begin
         if (tmr == '0)
            busy <= 1'b0;
         else
            tmr <= tmr - 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         tmr  <= TW'(WR_CYCLES - 1);
      end
   end
endmodule

// File: rtl/nvb_stall.sv
module nvb_stall #(
   parameter int WR_STALL = 2,
   parameter int RD_STALL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_start,
   input  logic rd_start,
   output logic stall
);
   localparam int MAXS = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;
   localparam int SW   = $clog2(MAXS + 1);

   logic [SW-1:0] cnt;

   assign stall = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (wr_start)
         cnt <= SW'(WR_STALL);
      else if (rd_start)
         cnt <= SW'(RD_STALL);
      else if (stall)
         cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl #(
   parameter int AW         = 7,
   parameter int DW         = 8,
   parameter int WR_CYCLES  = 64,
   parameter int WR_STALL   = 2,
   parameter int RD_STALL   = 4,
   parameter int ARM_WINDOW = 4
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          cpu_stall,
   output logic          ready_irq
);
   localparam int DEPTH = 2 ** AW;

   if (AW < 1 || AW >= DW)
      $error("nvbyte_ctrl: AW must be between 1 and DW-1");
   if (DW < 5)
      $error("nvbyte_ctrl: DW must hold the control bits");
   if (WR_CYCLES < 2)
      $error("nvbyte_ctrl: WR_CYCLES must be at least 2");
   if (WR_STALL < 1 || RD_STALL < 1 || ARM_WINDOW < 1)
      $error("nvbyte_ctrl: stall and arm windows must be positive");

   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] rd_byte;
   logic          ie_q, arm, arm_set, wr_start, rd_start;
   logic          wr_busy, commit;
   logic [DW-1:0] store [DEPTH];

   nvb_regs #(.AW(AW), .DW(DW), .ARM_WINDOW(ARM_WINDOW)) i_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .busy(wr_busy), .rd_byte(rd_byte),
      .addr_q(addr_q), .data_q(data_q), .ie_q(ie_q), .arm(arm),
      .arm_set(arm_set), .wr_start(wr_start), .rd_start(rd_start),
      .bus_rdata(bus_rdata)
   );

   nvb_wr_engine #(.WR_CYCLES(WR_CYCLES)) i_eng (
      .clk(clk), .por_n(por_n), .start(wr_start),
      .busy(wr_busy), .commit(commit)
   );

   nvb_stall #(.WR_STALL(WR_STALL), .RD_STALL(RD_STALL)) i_stall (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start),
      .rd_start(rd_start), .stall(cpu_stall)
   );

   always_ff @(posedge clk) begin
      if (commit)
         store[addr_q] <= data_q;
   end

   assign rd_byte   = store[addr_q];
   assign ready_irq = ie_q && !wr_busy;
endmodule

// File: rtl/nvb_checker.sv
module nvb_checker #(
   parameter int DW         = 8,
   parameter int AW         = 7,
   parameter int ARM_WINDOW = 4
) (
   input logic          clk,
   input logic          por_n,
   input logic          rst_n,
   input logic          busy,
   input logic          arm,
   input logic          arm_set,
   input logic          rd_start,
   input logic          cpu_stall,
   input logic          ready_irq,
   input logic          ie,
   input logic [AW-1:0] addr_q,
   input logic [DW-1:0] data_q,
   input logic [1:0]    bus_addr,
   input logic [DW-1:0] bus_rdata
);
   localparam int SW = $clog2(ARM_WINDOW + 2) + 1;

   logic [SW-1:0] since_arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_arm <= SW'(ARM_WINDOW + 1);
      else if (arm_set)
         since_arm <= SW'(1);
      else if (since_arm <= SW'(ARM_WINDOW))
         since_arm <= since_arm + 1'b1;
   end

   AST_ARM_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (since_arm > SW'(ARM_WINDOW)) |-> !arm); // R3
   AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $rose(busy) |-> $past(arm)); // R3
   AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $rose(busy) |-> cpu_stall ##1 cpu_stall ##1 !cpu_stall); // R6
   AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      rd_start |=> cpu_stall ##1 cpu_stall ##1 cpu_stall ##1 cpu_stall ##1 !cpu_stall); // R6
   AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
      (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q))); // R7
   AST_NO_RD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!por_n)
      busy |-> !rd_start); // R7
   AST_IRQ_LOW_BUSY: assert property (@(posedge clk) disable iff (!por_n)
      busy |-> !ready_irq); // R8
   AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      ($fell(busy) && ie) |-> ready_irq); // R8
   AST_ADDR_MSB_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      (bus_addr == 2'd1) |-> (bus_rdata[DW-1] == 1'b0)); // R2
endmodule

bind nvbyte_ctrl nvb_checker #(.DW(DW), .AW(AW), .ARM_WINDOW(ARM_WINDOW)) i_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .busy(wr_busy), .arm(arm),
   .arm_set(arm_set), .rd_start(rd_start), .cpu_stall(cpu_stall),
   .ready_irq(ready_irq), .ie(ie_q), .addr_q(addr_q), .data_q(data_q),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/test_nvbyte_ctrl.sv
`timescale 1ns/1ps
module test_nvbyte_ctrl;
   localparam int W = 64;
   localparam logic [1:0] O_CTRL = 2'd0, O_ADDR = 2'd1, O_DATA = 2'd2;
   localparam logic [7:0] IE = 8'h01, ARM = 8'h02, WGO = 8'h04, RGO = 8'h08;

   logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00, bus_rdata;
   logic cpu_stall, ready_irq;
   int checks = 0, failures = 0;

   always #5 clk = ~clk;

   nvbyte_ctrl i_nvbyte_ctrl (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_stall(cpu_stall), .ready_irq(ready_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] o, input logic [7:0] v);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = o; bus_wdata = v;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] o, output logic [7:0] v);
      bus_addr = o;
      #1 v = bus_rdata;
   endtask

   // counts stall and busy cycles from the negedge after the request
   task automatic run_out(output int ns, output int nb);
      logic [7:0] c;
      ns = 0; nb = 0;
      forever begin
         bus_rd(O_CTRL, c);
         if (cpu_stall) ns++;
         if (c[4]) nb++;
         if (!c[4] && !cpu_stall) break;
         @(negedge clk);
      end
   endtask

   task automatic store_byte(input logic [6:0] a, input logic [7:0] d, input logic [7:0] ie,
                             input string req);
      int ns, nb;
      bus_wr(O_ADDR, {1'b0, a});
      bus_wr(O_DATA, d);
      bus_wr(O_CTRL, ARM | ie);
      bus_wr(O_CTRL, WGO | ie);
      run_out(ns, nb);
      chk({req, " R6 store stall"}, ns, 2);
      chk({req, " R4 busy length"}, nb, W);
   endtask

   task automatic fetch_byte(input logic [6:0] a, output logic [7:0] d, output int ns);
      int nb;
      bus_wr(O_ADDR, {1'b0, a});
      bus_wr(O_CTRL, RGO);
      run_out(ns, nb);
      bus_rd(O_DATA, d);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      bus_rd(O_CTRL, v);
      chk("R8 reset ctrl", v, 0);
      chk("R8 reset irq", ready_irq, 0);
      chk("R6 reset stall", cpu_stall, 0);
   endtask

   task automatic t_addr_msb;
      logic [7:0] v;
      bus_wr(O_ADDR, 8'hFF);
      bus_rd(O_ADDR, v);
      chk("R2 msb dropped", v, 8'h7F);
   endtask

   task automatic t_store_fetch;
      logic [7:0] d; int ns;
      store_byte(7'd0, 8'hA5, 8'h00, "R1 loc0");
      store_byte(7'd127, 8'h3C, 8'h00, "R1 loc127");
      fetch_byte(7'd0, d, ns);
      chk("R9 fetch loc0", d, 8'hA5);
      chk("R6 fetch stall", ns, 4);
      fetch_byte(7'd127, d, ns);
      chk("R1 fetch loc127", d, 8'h3C);
   endtask

   task automatic t_unarmed;
      logic [7:0] v, d; int ns;
      store_byte(7'd3, 8'hC3, 8'h00, "R3 setup");
      bus_wr(O_DATA, 8'h00);
      bus_wr(O_CTRL, WGO);
      bus_rd(O_CTRL, v);
      chk("R3 unarmed busy", v[4], 0);
      chk("R3 unarmed stall", cpu_stall, 0);
      fetch_byte(7'd3, d, ns);
      chk("R3 unarmed content", d, 8'hC3);
   endtask

   task automatic t_arm_expiry;
      logic [7:0] v, d; int ns;
      bus_wr(O_ADDR, 8'd3);
      bus_wr(O_DATA, 8'h77);
      bus_wr(O_CTRL, ARM);
      bus_rd(O_CTRL, v);
      chk("R3 arm set", v[1], 1);
      repeat (4) @(negedge clk);
      bus_rd(O_CTRL, v);
      chk("R3 arm expired", v[1], 0);
      bus_wr(O_CTRL, WGO);
      bus_rd(O_CTRL, v);
      chk("R3 late go busy", v[4], 0);
      fetch_byte(7'd3, d, ns);
      chk("R3 late go content", d, 8'hC3);
   endtask

   task automatic t_busy_ignore;
      logic [7:0] v, d; int ns, nb;
      bus_wr(O_ADDR, 8'd5);
      bus_wr(O_DATA, 8'h5A);
      bus_wr(O_CTRL, ARM);
      bus_wr(O_CTRL, WGO);
      repeat (3) @(negedge clk);
      bus_wr(O_ADDR, 8'd9);
      bus_wr(O_DATA, 8'h11);
      bus_wr(O_CTRL, RGO);
      chk("R7 fetch while busy stall", cpu_stall, 0);
      bus_rd(O_ADDR, v);
      chk("R7 addr frozen", v, 8'd5);
      bus_rd(O_DATA, v);
      chk("R7 data frozen", v, 8'h5A);
      run_out(ns, nb);
      fetch_byte(7'd5, d, ns);
      chk("R7 committed", d, 8'h5A);
   endtask

   task automatic t_reset_mid;
      logic [7:0] v, d; int ns, nb;
      bus_wr(O_ADDR, 8'd20);
      bus_wr(O_DATA, 8'h96);
      bus_wr(O_CTRL, ARM | IE);
      bus_wr(O_CTRL, WGO | IE);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      bus_rd(O_CTRL, v);
      chk("R5 busy in reset", v[4], 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 enable cleared", ready_irq, 0);
      run_out(ns, nb);
      fetch_byte(7'd20, d, ns);
      chk("R5 commit through reset", d, 8'h96);
   endtask

   task automatic t_irq;
      bus_wr(O_CTRL, IE);
      chk("R8 irq idle", ready_irq, 1);
      bus_wr(O_ADDR, 8'd40);
      bus_wr(O_DATA, 8'h42);
      bus_wr(O_CTRL, ARM | IE);
      bus_wr(O_CTRL, WGO | IE);
      chk("R8 irq busy", ready_irq, 0);
      repeat (W) @(negedge clk);
      chk("R8 irq after store", ready_irq, 1);
      bus_wr(O_CTRL, 8'h00);
      chk("R8 irq disabled", ready_irq, 0);
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_msb();
      t_store_fetch();
      t_unarmed();
      t_arm_expiry();
      t_busy_ignore();
      t_reset_mid();
      t_irq();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule